// File: doc/BRIEF.md
# Timed Subsystem Wake Sequencer

This block brings two dependent subsystems out of reset in a fixed order and then wakes a peripheral controller with a timed pulse pattern on a single wake line. A one-cycle start pulse turns a status lamp on. On the next cycle the first subsystem's active-low reset is released. The second subsystem's reset is released after a short gap. The wake line then goes through an uneven low, high, low pattern before it settles high. At that moment the lamp goes dark and a one-cycle completion pulse is issued.

Every interval is measured in pulses of an external one-cycle millisecond strobe. The length of each interval is a parameter. A separate hold path keeps a supply-hold output asserted from a power-down request until a save-complete indication arrives.

Top module: `wake_seq_top`

## Requirements
- R1: While the synchronous reset is high, and on the cycle after it, the outputs are: both subsystem resets low, wake high, lamp low, completion low, supply-hold low.
- R2: A start pulse in the idle state lights the lamp in the next cycle with both resets still low. The first subsystem reset goes high one cycle later and the lamp stays lit.
- R3: The second subsystem reset goes high in the cycle after the GAP_TICKS-th strobe (default 2) counted from the first release. Strobes received before start are not counted.
- R4: The wake line goes low in the same cycle that the second reset is released. It stays low until the cycle after the WAKE_LO1_TICKS-th strobe (default 5).
- R5: The wake line then stays high for WAKE_HI_TICKS strobes (default 10).
- R6: The wake line then goes low again for WAKE_LO2_TICKS strobes (default 5). After that it returns high and stays high.
- R7: When the wake line returns high for the last time, the lamp goes low in the same cycle and the completion output is high for exactly that one cycle.
- R8: A start pulse is ignored while a sequence is running and after the sequence has completed. Outputs and interval timing are unchanged.
- R9: A power-down request raises supply-hold in the next cycle. Supply-hold stays high until a save-complete pulse, and falls in the cycle after that pulse. A request in the same cycle as a save-complete keeps supply-hold high.
- R10: A save-complete pulse while supply-hold is low has no effect.
- R11: A reset in mid-sequence or after completion returns every output to the idle values of R1 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle start request |
| tick_i | input | 1 | One-cycle millisecond strobe |
| pd_req_i | input | 1 | Power-down request |
| save_done_i | input | 1 | Save-complete indication |
| sub_a_rst_n_o | output | 1 | First subsystem reset, active low |
| sub_b_rst_n_o | output | 1 | Second subsystem reset, active low |
| wake_o | output | 1 | Wake line to the peripheral controller |
| led_o | output | 1 | Status lamp, high = on |
| done_o | output | 1 | One-cycle completion pulse |
| hold_o | output | 1 | Supply-hold, high = keep power |

## Verification
The full sequence is run with randomly spaced strobes. The state is checked one strobe before and exactly at each interval boundary, which catches off-by-one errors in the gap, low, high and second-low counts. A second run scatters start pulses among the strobes and after completion; this shows whether starts are truly ignored or whether they restart the flow. Mid-sequence and post-completion resets are compared against the idle values. The hold path gets a random mix of requests and save-completes, including both arriving together and save-completes with no hold active. This separates set priority from clear priority.

// File: rtl/wake_seq_pkg.sv
`timescale 1ns/1ps
package wake_seq_pkg;
   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_LAMP  = 3'd1,
      ST_REL_A = 3'd2,
      ST_WLO1  = 3'd3,
      ST_WHI   = 3'd4,
      ST_WLO2  = 3'd5,
      ST_FIN   = 3'd6,
      ST_RUN   = 3'd7
   } seq_state_t;

   typedef struct packed {
      logic rst_a_n;
      logic rst_b_n;
      logic wake;
      logic lamp;
      logic fin;
   } seq_pins_t;

   localparam seq_pins_t PINS_IDLE = '{rst_a_n: 1'b0, rst_b_n: 1'b0, wake: 1'b1,
                                       lamp: 1'b0, fin: 1'b0};

   function automatic seq_pins_t decode_pins(seq_state_t s);
      seq_pins_t p;
      p = PINS_IDLE;
      case (s)
         ST_LAMP:  p.lamp = 1'b1;
         ST_REL_A: begin p.lamp = 1'b1; p.rst_a_n = 1'b1; end
         ST_WLO1, ST_WLO2: begin
            p.lamp = 1'b1; p.rst_a_n = 1'b1; p.rst_b_n = 1'b1; p.wake = 1'b0;
         end
         ST_WHI: begin p.lamp = 1'b1; p.rst_a_n = 1'b1; p.rst_b_n = 1'b1; end
         ST_FIN: begin p.rst_a_n = 1'b1; p.rst_b_n = 1'b1; p.fin = 1'b1; end
         ST_RUN: begin p.rst_a_n = 1'b1; p.rst_b_n = 1'b1; end
         default: p = PINS_IDLE;
      endcase
      return p;
   endfunction
endpackage

// File: rtl/wake_seq_timer.sv
`timescale 1ns/1ps
module wake_seq_timer #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             en,
   input  logic             tick,
   input  logic [CNT_W-1:0] limit,
   output logic             expire
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic [CNT_W-1:0] cnt_q;
   logic             last;

   assign last   = (cnt_q == (limit - ONE));
   assign expire = en & tick & last;

   always_ff @(posedge clk) begin
      if (rst || !en) begin
         cnt_q <= '0;
      end else if (tick) begin
         cnt_q <= last ? '0 : cnt_q + ONE;
      end
   end
endmodule

// File: rtl/wake_seq_fsm.sv
`timescale 1ns/1ps
module wake_seq_fsm
   import wake_seq_pkg::*;
#(
   parameter int CNT_W          = 4,
   parameter int GAP_TICKS      = 2,
   parameter int WAKE_LO1_TICKS = 5,
   parameter int WAKE_HI_TICKS  = 10,
   parameter int WAKE_LO2_TICKS = 5
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             start,
   input  logic             expire,
   output seq_state_t       state,
   output logic             tmr_en,
   output logic [CNT_W-1:0] tmr_limit
);
   seq_state_t state_q, state_d;

   always_comb begin
      state_d = state_q;
      case (state_q)
         ST_IDLE:  if (start) state_d = ST_LAMP;
         ST_LAMP:  state_d = ST_REL_A;
         ST_REL_A: if (expire) state_d = ST_WLO1;
         ST_WLO1:  if (expire) state_d = ST_WHI;
         ST_WHI:   if (expire) state_d = ST_WLO2;
         ST_WLO2:  if (expire) state_d = ST_FIN;
         ST_FIN:   state_d = ST_RUN;
         default:  state_d = ST_RUN;
      endcase
   end

   always_comb begin
      tmr_en    = 1'b1;
      tmr_limit = CNT_W'(GAP_TICKS);
      case (state_q)
         ST_REL_A: tmr_limit = CNT_W'(GAP_TICKS);
         ST_WLO1:  tmr_limit = CNT_W'(WAKE_LO1_TICKS);
         ST_WHI:   tmr_limit = CNT_W'(WAKE_HI_TICKS);
         ST_WLO2:  tmr_limit = CNT_W'(WAKE_LO2_TICKS);
         default:  tmr_en    = 1'b0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) state_q <= ST_IDLE;
      else     state_q <= state_d;
   end

   assign state = state_q;
endmodule

// File: rtl/wake_seq_outs.sv
`timescale 1ns/1ps
module wake_seq_outs
   import wake_seq_pkg::*;
#(
   parameter bit REG_OUTPUTS = 1'b0
) (
   input  logic       clk,
   input  logic       rst,
   input  seq_state_t state,
   output seq_pins_t  pins
);
   seq_pins_t pins_c;
   assign pins_c = decode_pins(state);

   generate
      if (REG_OUTPUTS) begin : g_reg
         seq_pins_t pins_q;
         always_ff @(posedge clk) begin
            if (rst) pins_q <= PINS_IDLE;
            else     pins_q <= pins_c;
         end
         assign pins = pins_q;
      end else begin : g_comb
         logic unused_clk_rst;
         assign unused_clk_rst = clk ^ rst;
         assign pins = pins_c;
      end
   endgenerate
endmodule

// File: rtl/wake_seq_hold.sv
`timescale 1ns/1ps
module wake_seq_hold (
   input  logic clk,
   input  logic rst,
   input  logic req,
   input  logic saved,
   output logic hold
);
   logic hold_q;

   always_ff @(posedge clk) begin
      if (rst) hold_q <= 1'b0;
      else     hold_q <= req | (hold_q & ~saved);
   end

   assign hold = hold_q;
endmodule

// File: rtl/wake_seq_top.sv
`timescale 1ns/1ps
module wake_seq_top
   import wake_seq_pkg::*;
#(
   parameter int GAP_TICKS      = 2,
   parameter int WAKE_LO1_TICKS = 5,
   parameter int WAKE_HI_TICKS  = 10,
   parameter int WAKE_LO2_TICKS = 5,
   parameter bit REG_OUTPUTS    = 1'b0
) (
   input  logic clk,
   input  logic rst,
   input  logic start_i,
   input  logic tick_i,
   input  logic pd_req_i,
   input  logic save_done_i,
   output logic sub_a_rst_n_o,
   output logic sub_b_rst_n_o,
   output logic wake_o,
   output logic led_o,
   output logic done_o,
   output logic hold_o
);
   localparam int MAX_A = (GAP_TICKS > WAKE_LO1_TICKS) ? GAP_TICKS : WAKE_LO1_TICKS;
   localparam int MAX_B = (WAKE_HI_TICKS > WAKE_LO2_TICKS) ? WAKE_HI_TICKS : WAKE_LO2_TICKS;
   localparam int MAX_T = (MAX_A > MAX_B) ? MAX_A : MAX_B;
   localparam int CNT_W = (MAX_T < 2) ? 1 : $clog2(MAX_T + 1);

   generate
      if (GAP_TICKS < 1 || WAKE_LO1_TICKS < 1 || WAKE_HI_TICKS < 1 || WAKE_LO2_TICKS < 1)
      begin : g_bad_ticks
         $error("wake_seq_top: every interval needs at least one tick");
      end
   endgenerate

   seq_state_t       state;
   logic             tmr_en;
   logic [CNT_W-1:0] tmr_limit;
   logic             expire;
   seq_pins_t        pins;

   wake_seq_fsm #(
      .CNT_W(CNT_W), .GAP_TICKS(GAP_TICKS), .WAKE_LO1_TICKS(WAKE_LO1_TICKS),
      .WAKE_HI_TICKS(WAKE_HI_TICKS), .WAKE_LO2_TICKS(WAKE_LO2_TICKS)
   ) i_fsm (
      .clk(clk), .rst(rst), .start(start_i), .expire(expire),
      .state(state), .tmr_en(tmr_en), .tmr_limit(tmr_limit)
   );

   wake_seq_timer #(.CNT_W(CNT_W)) i_timer (
      .clk(clk), .rst(rst), .en(tmr_en), .tick(tick_i),
      .limit(tmr_limit), .expire(expire)
   );

   wake_seq_outs #(.REG_OUTPUTS(REG_OUTPUTS)) i_outs (
      .clk(clk), .rst(rst), .state(state), .pins(pins)
   );

   wake_seq_hold i_hold (
      .clk(clk), .rst(rst), .req(pd_req_i), .saved(save_done_i), .hold(hold_o)
   );

   assign sub_a_rst_n_o = pins.rst_a_n;
   assign sub_b_rst_n_o = pins.rst_b_n;
   assign wake_o        = pins.wake;
   assign led_o         = pins.lamp;
   assign done_o        = pins.fin;
endmodule

// File: rtl/wake_seq_chk.sv
`timescale 1ns/1ps
module wake_seq_chk (
   input logic clk,
   input logic rst,
   input logic start_i,
   input logic pd_req_i,
   input logic save_done_i,
   input logic sub_a_rst_n_o,
   input logic sub_b_rst_n_o,
   input logic wake_o,
   input logic led_o,
   input logic done_o,
   input logic hold_o
);
   assert_reset_idle_R11: assert property (@(posedge clk)
      rst |=> (!sub_a_rst_n_o && !sub_b_rst_n_o && wake_o && !led_o && !done_o && !hold_o));

   assert_lamp_first_R2: assert property (@(posedge clk) disable iff (rst)
      $rose(sub_a_rst_n_o) |-> led_o);

   assert_lamp_rise_R2: assert property (@(posedge clk) disable iff (rst)
      $rose(led_o) |-> (!sub_a_rst_n_o && !sub_b_rst_n_o));

   assert_order_R3: assert property (@(posedge clk) disable iff (rst)
      sub_b_rst_n_o |-> sub_a_rst_n_o);

   assert_wake_after_b_R4: assert property (@(posedge clk) disable iff (rst)
      !wake_o |-> sub_b_rst_n_o);

   assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
      done_o |=> !done_o);

   assert_done_state_R7: assert property (@(posedge clk) disable iff (rst)
      done_o |-> (wake_o && !led_o && sub_b_rst_n_o));

   assert_no_restart_R8: assert property (@(posedge clk) disable iff (rst)
      (sub_a_rst_n_o && start_i) |=> sub_a_rst_n_o);

   assert_hold_set_R9: assert property (@(posedge clk) disable iff (rst)
      pd_req_i |=> hold_o);

   assert_hold_keep_R9: assert property (@(posedge clk) disable iff (rst)
      (hold_o && !save_done_i) |=> hold_o);

   assert_hold_release_R9: assert property (@(posedge clk) disable iff (rst)
      (hold_o && save_done_i && !pd_req_i) |=> !hold_o);

   assert_hold_idle_R10: assert property (@(posedge clk) disable iff (rst)
      (!hold_o && !pd_req_i) |=> !hold_o);
endmodule

bind wake_seq_top wake_seq_chk i_chk (
   .clk(clk), .rst(rst), .start_i(start_i), .pd_req_i(pd_req_i),
   .save_done_i(save_done_i), .sub_a_rst_n_o(sub_a_rst_n_o),
   .sub_b_rst_n_o(sub_b_rst_n_o), .wake_o(wake_o), .led_o(led_o),
   .done_o(done_o), .hold_o(hold_o)
);

// File: tb/test_wake_seq_top.sv
`timescale 1ns/1ps
module test_wake_seq_top;
   localparam int GAP = 2;
   localparam int LO1 = 5;
   localparam int HI  = 10;
   localparam int LO2 = 5;

   localparam int PH_IDLE = 0, PH_LAMP = 1, PH_RELA = 2, PH_WLO1 = 3,
                  PH_WHI = 4, PH_WLO2 = 5, PH_FIN = 6, PH_RUN = 7;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic rst = 1'b1, start_i = 1'b0, tick_i = 1'b0, pd_req_i = 1'b0, save_done_i = 1'b0;
   logic sub_a_rst_n_o, sub_b_rst_n_o, wake_o, led_o, done_o, hold_o;

   int  n_chk = 0;
   int  n_err = 0;
   bit  reported = 1'b0;
   logic hold_exp = 1'b0;

   wake_seq_top #(
      .GAP_TICKS(GAP), .WAKE_LO1_TICKS(LO1), .WAKE_HI_TICKS(HI),
      .WAKE_LO2_TICKS(LO2), .REG_OUTPUTS(1'b0)
   ) i_wake_seq_top (
      .clk(clk), .rst(rst), .start_i(start_i), .tick_i(tick_i),
      .pd_req_i(pd_req_i), .save_done_i(save_done_i),
      .sub_a_rst_n_o(sub_a_rst_n_o), .sub_b_rst_n_o(sub_b_rst_n_o),
      .wake_o(wake_o), .led_o(led_o), .done_o(done_o), .hold_o(hold_o)
   );

   // {rst_a_n, rst_b_n, wake, lamp, done} expected for each phase of the flow
   function automatic logic [4:0] phase_vec(int ph);
      case (ph)
         PH_LAMP: return 5'b00110;
         PH_RELA: return 5'b10110;
         PH_WLO1: return 5'b11010;
         PH_WHI:  return 5'b11110;
         PH_WLO2: return 5'b11010;
         PH_FIN:  return 5'b11101;
         PH_RUN:  return 5'b11100;
         default: return 5'b00100;
      endcase
   endfunction

   function automatic logic hold_model(logic cur, logic req, logic saved);
      return req | (cur & ~saved);
   endfunction

   task automatic expect_pins(string req, logic [5:0] exp);
      logic [5:0] act;
      act = {sub_a_rst_n_o, sub_b_rst_n_o, wake_o, led_o, done_o, hold_o};
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=%b expected=%b (rstA,rstB,wake,lamp,done,hold)", req, act, exp);
      end
   endtask

   task automatic expect_phase(string req, int ph);
      expect_pins(req, {phase_vec(ph), hold_exp});
   endtask

   task automatic pulse_tick();
      tick_i = 1'b1;
      @(negedge clk);
      tick_i = 1'b0;
   endtask

   task automatic do_ticks(int n, bit poke);
      for (int i = 0; i < n; i++) begin
         int gap;
         gap = $urandom_range(0, 3);
         for (int g = 0; g < gap; g++) begin
            if (poke && $urandom_range(0, 1) == 1) start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
         end
         pulse_tick();
      end
   endtask

   task automatic span(int n, int cur, int nxt, string req, bit poke);
      do_ticks(n - 1, poke);
      expect_phase(req, cur);
      do_ticks(1, poke);
      expect_phase(req, nxt);
   endtask

   task automatic run_full(bit poke);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      expect_phase("R2 lamp on, resets held", PH_LAMP);
      @(negedge clk);
      expect_phase("R2 first reset released", PH_RELA);
      span(GAP, PH_RELA, PH_WLO1, poke ? "R8 R3 gap" : "R3 gap", poke);
      span(LO1, PH_WLO1, PH_WHI, poke ? "R8 R4 first low" : "R4 first low", poke);
      span(HI, PH_WHI, PH_WLO2, poke ? "R8 R5 high" : "R5 high", poke);
      span(LO2, PH_WLO2, PH_FIN, poke ? "R8 R6 second low" : "R6 second low", poke);
      expect_phase("R7 done pulse, lamp off", PH_FIN);
      @(negedge clk);
      expect_phase("R7 done single cycle", PH_RUN);
      if (poke) begin
         start_i = 1'b1;
         @(negedge clk);
         start_i = 1'b0;
         repeat (3) @(negedge clk);
         expect_phase("R8 start after completion", PH_RUN);
      end
   endtask

   task automatic apply_reset();
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      hold_exp = 1'b0;
   endtask

   task automatic finish_run();
      if (!reported) begin
         reported = 1'b1;
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=running expected=finished");
      finish_run();
   end

   initial begin
      void'($urandom(32'd20240601));
      repeat (3) @(negedge clk);
      expect_phase("R1 during reset", PH_IDLE);
      rst = 1'b0;
      @(negedge clk);
      expect_phase("R1 after reset", PH_IDLE);

      // strobes before start must not count toward the gap
      repeat (3) pulse_tick();
      expect_phase("R3 ticks in idle ignored", PH_IDLE);

      run_full(1'b0);

      apply_reset();
      expect_phase("R11 reset after completion", PH_IDLE);

      // reset in the middle of the first low interval
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      @(negedge clk);
      do_ticks(GAP, 1'b0);
      do_ticks(2, 1'b0);
      expect_phase("R4 mid first low", PH_WLO1);
      apply_reset();
      expect_phase("R11 reset mid-sequence", PH_IDLE);

      run_full(1'b1);
      apply_reset();

      // directed hold corners
      save_done_i = 1'b1;
      @(negedge clk);
      save_done_i = 1'b0;
      expect_phase("R10 save without hold", PH_IDLE);
      pd_req_i = 1'b1;
      save_done_i = 1'b1;
      hold_exp = 1'b1;
      @(negedge clk);
      pd_req_i = 1'b0;
      save_done_i = 1'b0;
      expect_phase("R9 request wins over save", PH_IDLE);
      repeat (4) @(negedge clk);
      expect_phase("R9 hold kept", PH_IDLE);
      save_done_i = 1'b1;
      hold_exp = 1'b0;
      @(negedge clk);
      save_done_i = 1'b0;
      expect_phase("R9 hold released", PH_IDLE);

      // random hold traffic
      for (int k = 0; k < 80; k++) begin
         logic was;
         was = hold_exp;
         pd_req_i    = ($urandom_range(0, 3) == 0);
         save_done_i = ($urandom_range(0, 2) == 0);
         hold_exp = hold_model(hold_exp, pd_req_i, save_done_i);
         @(negedge clk);
         expect_phase((!was && !pd_req_i) ? "R10 random" : "R9 random", PH_IDLE);
         pd_req_i = 1'b0;
         save_done_i = 1'b0;
      end

      finish_run();
   end
endmodule